// File: doc/BRIEF.md
# SPI Channel Interrupt Status Controller

This block gathers the event flags of a multichannel SPI controller into one status register and drives a single interrupt line. Each channel's datapath sends one-cycle pulses for transmit-empty, transmit-underflow and receive-full. Channel 0 also sends receive-overflow, and a wake-up pulse is shared by all channels. A status bit stays set until software writes 1 to it. An enable register decides which set bits reach the interrupt line. Bits that are not enabled can still be polled.

Two of the event classes are level-like: receive-full and transmit-empty. For each of these the block keeps a source flag that records whether the condition is still present. A receive-full condition goes away only when that channel's receive data register is read. A transmit-empty condition goes away only when that channel's transmit data register is written. Per-channel strobes from the data registers report these reads and writes. If software clears the status bit while the source flag is still set, the bit sets again. The other event classes have no source to remove, so clearing them is final.

Top module: `spi_irq_top`

## Requirements
- R1: After reset, the status register, the enable register and all source flags are 0, and `irq` is 0.
- R2: Bit layout: channel c uses bit 4c for transmit-empty, bit 4c+1 for transmit-underflow and bit 4c+2 for receive-full. Bit 3 is receive-overflow, which exists on channel 0 only. Bit 4·NUM_CH is wake-up. An event pulse in cycle t makes its status bit read 1 from cycle t+1, whatever the enable.
- R3: A write to address 0 clears every status bit whose data bit is 1. Status bits written with 0 keep their value.
- R4: If an event pulse arrives in the same cycle as a write-1-to-clear of its bit, the bit reads 1 afterwards.
- R5: A write to address 1 loads the enable register. Bit positions that carry no event (4c+3 for c>0) always read 0 in both registers.
- R6: `irq` is 1 exactly when some status bit and its enable bit are both 1. It falls in the cycle after the write that clears the last such bit or disables it.
- R7: A set status bit whose enable is 0 does not raise `irq`, and clearing that bit does not change `irq`.
- R8: A receive-full bit cleared while its source is present reads 0 for one cycle and then reads 1 again. A `rxReadStb` pulse for that channel removes the source, after which a clear is final.
- R9: A transmit-empty source is removed only by a `txWriteStb` pulse for its channel. A receive-data read on the same channel leaves it in place.
- R10: Clearing transmit-underflow, receive-overflow or wake-up is final, and the bit stays 0 until a new pulse arrives.
- R11: A source-removal strobe in the same cycle as a new event pulse for the same source leaves the source present.
- R12: `busRdData` shows the status register when `busAddr` is 0 and the enable register when it is 1, in the same cycle. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 selects status, 1 selects enable |
| busWrData | input | REG_W | Write data (REG_W = 4·NUM_CH+1) |
| busRdData | output | REG_W | Read data for the selected register |
| rxFullEvt | input | NUM_CH | Receive-full pulse per channel |
| txEmptyEvt | input | NUM_CH | Transmit-empty pulse per channel |
| txUnderEvt | input | NUM_CH | Transmit-underflow pulse per channel |
| rxOverEvt | input | 1 | Receive-overflow pulse, channel 0 |
| wakeEvt | input | 1 | Wake-up pulse |
| rxReadStb | input | NUM_CH | Receive data register was read |
| txWriteStb | input | NUM_CH | Transmit data register was written |
| irq | output | 1 | Interrupt line |

## Verification
A wrong status or enable bit shows on `busRdData` in the first cycle after the faulty update. When that bit is enabled, it also shows on `irq` in the same cycle. A source flag cannot be read directly. A wrong source flag therefore appears one cycle after the next clear of its status bit: the bit either sets again when it should stay 0, or stays 0 when it should set again. For this reason, clears are issued while sources are present and again after they have been removed.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int SLOTS_PER_CH = 4;

  typedef enum logic [1:0] {
    EV_TX_EMPTY = 2'd0,
    EV_TX_UNDER = 2'd1,
    EV_RX_FULL  = 2'd2,
    EV_RX_OVER  = 2'd3
  } evSlot_t;

  typedef struct packed {
    logic statusClr;
    logic enableLoad;
    logic readEnable;
  } irqStrobe_t;

  function automatic int slotBit(int ch, evSlot_t slot);
    return ch * SLOTS_PER_CH + int'(slot);
  endfunction

  function automatic int wakeBit(int numCh);
    return numCh * SLOTS_PER_CH;
  endfunction

  function automatic int regWidth(int numCh);
    return numCh * SLOTS_PER_CH + 1;
  endfunction

endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = regWidth(NUM_CH)
) (
  input  logic              busWrEn,
  input  logic              busAddr,
  input  logic [NUM_CH-1:0] rxReadStb,
  input  logic [NUM_CH-1:0] txWriteStb,
  output irqStrobe_t        strobe,
  output logic [REG_W-1:0]  srcDrop
);

  // Register decode: address 0 is the status register, address 1 is enable.
  always_comb begin
    strobe.statusClr  = busWrEn && !busAddr;
    strobe.enableLoad = busWrEn && busAddr;
    strobe.readEnable = busAddr;
  end

  // Source-removal rules: a receive read retires receive-full and a
  // transmit write retires transmit-empty. The other classes have no source.
  always_comb begin
    srcDrop = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      srcDrop[slotBit(c, EV_RX_FULL)]  = rxReadStb[c];
      srcDrop[slotBit(c, EV_TX_EMPTY)] = txWriteStb[c];
    end
  end

endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = regWidth(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strobe,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  srcDrop,
  input  logic [NUM_CH-1:0] rxFullEvt,
  input  logic [NUM_CH-1:0] txEmptyEvt,
  input  logic [NUM_CH-1:0] txUnderEvt,
  input  logic              rxOverEvt,
  input  logic              wakeEvt,
  output logic [REG_W-1:0]  statusQ,
  output logic [REG_W-1:0]  enableQ,
  output logic [REG_W-1:0]  srcQ,
  output logic [REG_W-1:0]  rdData,
  output logic              irq
);

  function automatic logic [REG_W-1:0] mkValid();
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[slotBit(c, EV_TX_EMPTY)] = 1'b1;
      m[slotBit(c, EV_TX_UNDER)] = 1'b1;
      m[slotBit(c, EV_RX_FULL)]  = 1'b1;
    end
    m[slotBit(0, EV_RX_OVER)] = 1'b1;
    m[wakeBit(NUM_CH)]        = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] mkLevel();
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[slotBit(c, EV_TX_EMPTY)] = 1'b1;
      m[slotBit(c, EV_RX_FULL)]  = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] VALID_MASK = mkValid();
  localparam logic [REG_W-1:0] LEVEL_MASK = mkLevel();
  localparam int               WAKE_IDX   = wakeBit(NUM_CH);
  localparam int               OVER_IDX   = slotBit(0, EV_RX_OVER);

  logic [REG_W-1:0] evtVec;
  logic [REG_W-1:0] clrMask;
  logic [REG_W-1:0] statusD;
  logic [REG_W-1:0] srcD;

  // Flatten the per-channel pulses into the status bit layout.
  always_comb begin
    evtVec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      evtVec[slotBit(c, EV_TX_EMPTY)] = txEmptyEvt[c];
      evtVec[slotBit(c, EV_TX_UNDER)] = txUnderEvt[c];
      evtVec[slotBit(c, EV_RX_FULL)]  = rxFullEvt[c];
    end
    evtVec[OVER_IDX] = rxOverEvt;
    evtVec[WAKE_IDX] = wakeEvt;
  end

  assign clrMask = strobe.statusClr ? (wrData & VALID_MASK) : '0;

  // A present source sets its bit again unless a clear hits in this cycle.
  // A new pulse always beats a clear.
  assign statusD = ((statusQ | srcQ) & ~clrMask) | evtVec;

  // A new pulse beats a removal strobe arriving in the same cycle.
  assign srcD = (srcQ & ~srcDrop) | (evtVec & LEVEL_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      srcQ    <= '0;
    end else begin
      statusQ <= statusD;
      srcQ    <= srcD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strobe.enableLoad) begin
      enableQ <= wrData & VALID_MASK;
    end
  end

  assign rdData = strobe.readEnable ? enableQ : statusQ;
  assign irq    = |(statusQ & enableQ);

endmodule

// File: rtl/spi_irq_top.sv
module spi_irq_top
  import spi_irq_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int REG_W  = regWidth(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic [NUM_CH-1:0] rxFullEvt,
  input  logic [NUM_CH-1:0] txEmptyEvt,
  input  logic [NUM_CH-1:0] txUnderEvt,
  input  logic              rxOverEvt,
  input  logic              wakeEvt,
  input  logic [NUM_CH-1:0] rxReadStb,
  input  logic [NUM_CH-1:0] txWriteStb,
  output logic              irq
);

  irqStrobe_t       strobe;
  logic [REG_W-1:0] srcDrop;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] enableQ;
  logic [REG_W-1:0] srcQ;

  spi_irq_ctrl #(.NUM_CH(NUM_CH), .REG_W(REG_W)) i_ctrl (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .rxReadStb (rxReadStb),
    .txWriteStb(txWriteStb),
    .strobe    (strobe),
    .srcDrop   (srcDrop)
  );

  spi_irq_datapath #(.NUM_CH(NUM_CH), .REG_W(REG_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .srcDrop   (srcDrop),
    .rxFullEvt (rxFullEvt),
    .txEmptyEvt(txEmptyEvt),
    .txUnderEvt(txUnderEvt),
    .rxOverEvt (rxOverEvt),
    .wakeEvt   (wakeEvt),
    .statusQ   (statusQ),
    .enableQ   (enableQ),
    .srcQ      (srcQ),
    .rdData    (busRdData),
    .irq       (irq)
  );

endmodule

// File: rtl/spi_irq_checker.sv
module spi_irq_checker
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = regWidth(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busAddr,
  input logic [REG_W-1:0]  busWrData,
  input logic [NUM_CH-1:0] rxFullEvt,
  input logic              wakeEvt,
  input logic              irq,
  input logic [REG_W-1:0]  statusQ,
  input logic [REG_W-1:0]  enableQ,
  input logic [REG_W-1:0]  srcQ
);

  localparam int WAKE = wakeBit(NUM_CH);
  localparam int RXF0 = slotBit(0, EV_RX_FULL);

  logic clrWake;
  logic clrRxf0;
  assign clrWake = busWrEn && !busAddr && busWrData[WAKE];
  assign clrRxf0 = busWrEn && !busAddr && busWrData[RXF0];

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |=> statusQ[WAKE]); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[WAKE] && !clrWake |=> statusQ[WAKE]); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrWake && wakeEvt |=> statusQ[WAKE]); // R4

  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr |=> enableQ[WAKE] == $past(busWrData[WAKE])); // R5

  AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busWrEn)); // R6

  AST_RX_REARM: assert property (@(posedge clk) disable iff (!rstN)
    srcQ[RXF0] && !clrRxf0 |=> statusQ[RXF0]); // R8

  AST_CLEAR_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    clrWake && !wakeEvt |=> !statusQ[WAKE]); // R10

  AST_SOURCE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    rxFullEvt[0] |=> srcQ[RXF0]); // R11

endmodule

bind spi_irq_top spi_irq_checker #(.NUM_CH(NUM_CH), .REG_W(REG_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .rxFullEvt(rxFullEvt),
  .wakeEvt  (wakeEvt),
  .irq      (irq),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .srcQ     (srcQ)
);

// File: tb/test_spi_irq_top.sv
module test_spi_irq_top;

  localparam int NC = 4;
  localparam int RW = 4 * NC + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic          busAddr = 1'b0;
  logic [RW-1:0] busWrData = '0;
  logic [RW-1:0] busRdData;
  logic [NC-1:0] rxFullEvt = '0;
  logic [NC-1:0] txEmptyEvt = '0;
  logic [NC-1:0] txUnderEvt = '0;
  logic          rxOverEvt = 1'b0;
  logic          wakeEvt = 1'b0;
  logic [NC-1:0] rxReadStb = '0;
  logic [NC-1:0] txWriteStb = '0;
  logic          irq;

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  bit    finished = 1'b0;

  logic [RW-1:0] mStat = '0;
  logic [RW-1:0] mEn = '0;
  logic [RW-1:0] mSrc = '0;

  always #10 clk = ~clk;

  spi_irq_top #(.NUM_CH(NC)) i_spi_irq_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .rxFullEvt(rxFullEvt),
    .txEmptyEvt(txEmptyEvt), .txUnderEvt(txUnderEvt), .rxOverEvt(rxOverEvt),
    .wakeEvt(wakeEvt), .rxReadStb(rxReadStb), .txWriteStb(txWriteStb),
    .irq(irq)
  );

  function automatic bit bitExists(int b);
    if (b == 4 * NC) return 1'b1;
    if (b > 4 * NC) return 1'b0;
    return (b % 4 != 3) || (b == 3);
  endfunction

  function automatic bit hasSource(int b);
    return (b < 4 * NC) && ((b % 4 == 0) || (b % 4 == 2));
  endfunction

  function automatic bit pulseFor(int b);
    if (b == 4 * NC) return wakeEvt;
    if (b == 3) return rxOverEvt;
    case (b % 4)
      0: return txEmptyEvt[b / 4];
      1: return txUnderEvt[b / 4];
      2: return rxFullEvt[b / 4];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit retireFor(int b);
    if (b % 4 == 0) return txWriteStb[b / 4];
    if (b % 4 == 2) return rxReadStb[b / 4];
    return 1'b0;
  endfunction

  task automatic modelStep();
    logic [RW-1:0] nStat, nSrc, nEn;
    nStat = mStat; nSrc = mSrc; nEn = mEn;
    if (!rstN) begin
      nStat = '0; nSrc = '0; nEn = '0;
    end else begin
      for (int b = 0; b < RW; b++) begin
        if (bitExists(b)) begin
          bit cleared;
          cleared = busWrEn && !busAddr && busWrData[b];
          if (pulseFor(b)) nStat[b] = 1'b1;
          else if (cleared) nStat[b] = 1'b0;
          else if (mSrc[b]) nStat[b] = 1'b1;
          if (hasSource(b)) begin
            if (pulseFor(b)) nSrc[b] = 1'b1;
            else if (retireFor(b)) nSrc[b] = 1'b0;
          end
          if (busWrEn && busAddr) nEn[b] = busWrData[b];
        end
      end
    end
    mStat = nStat; mSrc = nSrc; mEn = nEn;
  endtask

  task automatic compareNow();
    logic [RW-1:0] expRd;
    logic          expIrq;
    expRd  = busAddr ? mEn : mStat;
    expIrq = 1'b0;
    for (int b = 0; b < RW; b++) if (mStat[b] && mEn[b]) expIrq = 1'b1;
    vectors++;
    if (busRdData !== expRd || irq !== expIrq) begin
      miscompares++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", curReq,
               busRdData, irq, expRd, expIrq);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareNow();
  endtask

  task automatic checkVal(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    busWrEn = 1'b0; busWrData = '0;
    rxFullEvt = '0; txEmptyEvt = '0; txUnderEvt = '0;
    rxOverEvt = 1'b0; wakeEvt = 1'b0; rxReadStb = '0; txWriteStb = '0;
  endtask

  task automatic writeReg(logic a, logic [RW-1:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    tick();
    quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    busAddr = 1'b0; tick();
    checkVal("R1", busRdData, '0);
    checkVal("R1", {{(RW-1){1'b0}}, irq}, '0);
    busAddr = 1'b1; tick();
    checkVal("R1", busRdData, '0);

    // R5: enable load, unused positions read 0
    curReq = "R5";
    writeReg(1'b1, '1);
    busAddr = 1'b1; tick();
    checkVal("R5", busRdData, 17'h1777F);
    // R12: status write leaves enable alone
    curReq = "R12";
    writeReg(1'b0, '1);
    busAddr = 1'b1; tick();
    checkVal("R12", busRdData, 17'h1777F);
    writeReg(1'b1, '0);

    // R7, R2: disabled events still set status, irq stays low
    curReq = "R7";
    rxFullEvt = '1; txEmptyEvt = '1; txUnderEvt = '1; rxOverEvt = 1'b1; wakeEvt = 1'b1;
    busAddr = 1'b0; tick(); quiet();
    checkVal("R2", busRdData, 17'h1777F);
    checkVal("R7", {{(RW-1){1'b0}}, irq}, '0);

    // R3: zeros keep, ones clear; R10 wake clear final
    curReq = "R3";
    writeReg(1'b0, '0);
    checkVal("R3", busRdData, 17'h1777F);
    writeReg(1'b0, 17'h10000);
    checkVal("R3", busRdData, 17'h0777F);
    curReq = "R10"; tick(); tick();
    checkVal("R10", busRdData, 17'h0777F);

    // R8, R9, R10: clear all, level bits set again one cycle later
    curReq = "R8";
    writeReg(1'b0, '1);
    checkVal("R8", busRdData, '0);
    tick();
    checkVal("R8", busRdData, 17'h05555);
    checkVal("R10", busRdData & 17'h1222A, '0);

    // R8: receive read on channel 1 retires its source; R9 keeps tx source
    rxReadStb[1] = 1'b1; tick(); quiet();
    writeReg(1'b0, 17'h00050);
    tick();
    checkVal("R8", busRdData, 17'h05515);
    curReq = "R9";
    txWriteStb[1] = 1'b1; tick(); quiet();
    writeReg(1'b0, 17'h00010);
    tick();
    checkVal("R9", busRdData, 17'h05505);

    // R4: set beats clear in the same cycle
    curReq = "R4";
    wakeEvt = 1'b1; busWrEn = 1'b1; busAddr = 1'b0; busWrData = 17'h10000;
    tick(); quiet();
    checkVal("R4", busRdData & 17'h10000, 17'h10000);

    // R6: enabled wake drives irq, clear drops it the next cycle
    curReq = "R6";
    writeReg(1'b1, 17'h10000);
    busAddr = 1'b0;
    checkVal("R6", {{(RW-1){1'b0}}, irq}, 17'h1);
    txUnderEvt[2] = 1'b1; tick(); quiet();
    curReq = "R7";
    writeReg(1'b0, 17'h00200);
    checkVal("R7", {{(RW-1){1'b0}}, irq}, 17'h1);
    curReq = "R6";
    writeReg(1'b0, 17'h10000);
    checkVal("R6", {{(RW-1){1'b0}}, irq}, '0);

    // R11: new pulse beats retire in the same cycle
    curReq = "R11";
    rxReadStb[2] = 1'b1; tick(); quiet();
    writeReg(1'b0, 17'h00400); tick();
    checkVal("R11", busRdData & 17'h00400, '0);
    rxFullEvt[2] = 1'b1; rxReadStb[2] = 1'b1; tick(); quiet();
    writeReg(1'b0, 17'h00400);
    checkVal("R11", busRdData & 17'h00400, '0);
    tick();
    checkVal("R11", busRdData & 17'h00400, 17'h00400);

    // Mixed traffic against the reference model
    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      busWrEn    = ($urandom % 4) == 0;
      busAddr    = ($urandom % 3) == 0;
      busWrData  = RW'($urandom);
      rxFullEvt  = NC'($urandom) & NC'($urandom);
      txEmptyEvt = NC'($urandom) & NC'($urandom);
      txUnderEvt = NC'($urandom) & NC'($urandom) & NC'($urandom);
      rxOverEvt  = ($urandom % 8) == 0;
      wakeEvt    = ($urandom % 8) == 0;
      rxReadStb  = NC'($urandom);
      txWriteStb = NC'($urandom);
      tick();
    end
    quiet();
    tick();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule